// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Engine

This block is a small multi-channel DMA engine that masters a single memory bus. Each channel keeps its transfer setup in a descriptor table in system memory. When a channel is requested, the engine fetches that channel's descriptor and copies data from a source to a destination. Either side may be a memory buffer or a fixed peripheral register. Each descriptor carries end pointers rather than start pointers. The address of each access is derived by subtracting the scaled remaining count from the end pointer.

The engine processes the remaining count in batches of 2^R transfers, where R is a field of the control word. At the end of each batch it writes the updated count back to the descriptor and then arbitrates among the channels again. Each channel has a primary and an alternate descriptor, which supports double buffering: in ping-pong mode the channel swaps descriptors whenever one completes. The two lowest channels can also run in loop mode, where the count is reloaded from a per-channel register so the stream never stops.

Top module: `dma_engine`

## Requirements
- R1: While reset is held and directly after it, `mem_req`, `chan_done` and `chan_err` are all low.
- R2: The descriptor of channel c lies at (tbl_base with its low 8 bits cleared) + c*16 for the primary copy, and 0x100 higher for the alternate copy. The engine reads the words at offsets 0 (source end pointer), 4 (destination end pointer) and 8 (control word), in that order.
- R3: The control word fields are: [31:30] destination step, [29:28] destination size, [27:26] source step, [25:24] source size, [17:14] batch exponent R, [13:4] remaining count minus one N, [2:0] mode. Every other bit passes through any writeback unchanged.
- R4: A descriptor moves N+1 items, each as a read followed by a write. The address of each access is the end pointer minus N times the step. Step codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=fixed address. `mem_size` carries the size field: 0=byte, 1=halfword, 2=word.
- R5: After every 2^R transfers that do not finish the descriptor, the decremented N is written to offset 8. The bus is then re-arbitrated, and the lowest-numbered pending channel wins.
- R6: When a descriptor in mode 1 (basic) or mode 2 (auto) completes, the control word is written back with N=0 and mode=0. One cycle after that write, the channel's `chan_done` bit pulses for exactly one cycle, and the channel stops.
- R7: When a descriptor in mode 3 (ping-pong) completes, it is written back with mode=0, `chan_done` pulses, and the channel switches to its other descriptor and carries on. The channel stops only when it fetches a descriptor in mode 0.
- R8: Channels 0 and 1 with their `loop_en` bit set do not stop on completion. N is reloaded from that channel's `loop_cnt` slice, the mode is kept, `chan_done` pulses, and transfers continue.
- R9: If the source and destination sizes differ, if a size is 3, if step 1 is used with byte size, if step 2 is used with a size other than word, or if the mode is above 3, the engine pulses `chan_err`, makes no data access and does no writeback.
- R10: A fetched descriptor in mode 0 causes no data access, no writeback and no done pulse.
- R11: A request that is not granted is held with the same address and write enable until it is granted.
- R12: A one-cycle `chan_req` pulse is enough to start a channel, even when it arrives while another channel is transferring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | AW | Descriptor table base address (bits [7:0] are ignored) |
| loop_en | input | NLOOP | Loop mode enable for channels 0..NLOOP-1 |
| loop_cnt | input | NLOOP*NW | Reload value of N for each loop channel |
| chan_req | input | NCH | Per-channel transfer request |
| chan_done | output | NCH | Per-channel completion pulse |
| chan_err | output | NCH | Per-channel illegal-descriptor pulse |
| mem_req | output | 1 | Bus access request |
| mem_gnt | input | 1 | Bus grant; read data is valid in the grant cycle |
| mem_addr | output | AW | Bus address |
| mem_we | output | 1 | Write enable |
| mem_size | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |

## Verification
Two functions can land in the same cycle. The first is a higher-priority channel's request being latched. The second is a batch-boundary writeback of another channel, which is followed at once by re-arbitration. This is provoked by starting channel 1 with a two-transfer batch and raising channel 0's request just after channel 1's first data write. The case is judged from the order of the logged data writes: channel 0's single write must appear third. It is also judged from the intermediate count that channel 1 writes back. Ping-pong completion, where a descriptor swap coincides with a still-pending request, is judged by where the data of each descriptor lands and by the stop marks written into both descriptors.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam int CTL_W = 32;
  localparam int CNT_W = 10;

  localparam logic [2:0] MODE_STOP  = 3'd0;
  localparam logic [2:0] MODE_BASIC = 3'd1;
  localparam logic [2:0] MODE_AUTO  = 3'd2;
  localparam logic [2:0] MODE_PING  = 3'd3;

  typedef struct packed {
    logic [1:0]       dst_step;
    logic [1:0]       dst_size;
    logic [1:0]       src_step;
    logic [1:0]       src_size;
    logic [1:0]       rsv_a;
    logic             wr_prio;
    logic [1:0]       rsv_b;
    logic             rd_prio;
    logic [3:0]       batch_exp;
    logic [CNT_W-1:0] remain;
    logic             burst;
    logic [2:0]       mode;
  } ctl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FSRC, S_FDST, S_FCTL, S_CHK, S_RD, S_WR, S_WB
  } dstate_t;

  typedef enum logic [1:0] {
    FIN_NONE, FIN_STOP, FIN_SWAP, FIN_LOOP
  } fin_t;

  function automatic logic step_bad(input logic [1:0] step, input logic [1:0] size);
    return ((step == 2'd1) && (size == 2'd0)) || ((step == 2'd2) && (size != 2'd2));
  endfunction

  function automatic logic ctl_bad(input ctl_t c);
    return (c.src_size != c.dst_size) || (c.src_size == 2'd3) || (c.mode > MODE_PING) ||
           step_bad(c.src_step, c.src_size) || step_bad(c.dst_step, c.dst_size);
  endfunction

endpackage

// File: rtl/dma_pending.sv
module dma_pending #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] clr,
  input  logic [NCH-1:0] swap,
  output logic [NCH-1:0] pend,
  output logic [NCH-1:0] alt
);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic pend_n, alt_n;

    always_comb begin
      pend_n = (pend[g] & ~clr[g]) | req[g];
      alt_n  = alt[g] ^ swap[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[g] <= 1'b0;
        alt[g]  <= 1'b0;
      end else begin
        pend[g] <= pend_n;
        if (swap[g]) alt[g] <= alt_n;
      end
    end
  end

endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] pend,
  output logic           any,
  output logic [IW-1:0]  idx
);

  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/dma_addr.sv
module dma_addr #(
  parameter int AW = 32,
  parameter int NW = 10
) (
  input  logic [AW-1:0] end_ptr,
  input  logic [NW-1:0] remain,
  input  logic [1:0]    step,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] offs;

  always_comb begin
    case (step)
      2'd0:    offs = AW'(remain);
      2'd1:    offs = AW'(remain) << 1;
      2'd2:    offs = AW'(remain) << 2;
      default: offs = '0;
    endcase
    addr = end_ptr - offs;
  end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int AW    = 32,
  parameter int NLOOP = 2,
  parameter int NW    = CNT_W,
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BW   = NW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       tbl_base,
  input  logic [NLOOP-1:0]    loop_en,
  input  logic [NLOOP*NW-1:0] loop_cnt,
  input  logic [NCH-1:0]      chan_req,
  output logic [NCH-1:0]      chan_done,
  output logic [NCH-1:0]      chan_err,
  output logic                mem_req,
  input  logic                mem_gnt,
  output logic [AW-1:0]       mem_addr,
  output logic                mem_we,
  output logic [1:0]          mem_size,
  output logic [31:0]         mem_wdata,
  input  logic [31:0]         mem_rdata
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  dstate_t       st, st_n;
  logic [IW-1:0] cur, cur_n;
  logic [AW-1:0] src_end, dst_end;
  ctl_t          ctl, ctl_n;
  logic [31:0]   dat;
  logic [BW-1:0] bcnt, bcnt_n, bc_p1, blen;
  fin_t          fin, fin_n;
  logic          ld_src, ld_dst, ld_ctl, ld_dat, ld_cur, ld_bc, ld_fin;
  logic [NCH-1:0] clr, swap, done_n, err_n, pend, alt;
  logic           any;
  logic [IW-1:0]  widx;
  logic [AW-1:0]  dbase, saddr, daddr;

  // loop-capable channel wiring
  logic [NCH-1:0] loop_on;
  logic [NW-1:0]  loop_val [NCH];
  for (genvar g = 0; g < NCH; g++) begin : g_loop
    if (g < NLOOP) begin : g_yes
      assign loop_on[g]  = loop_en[g];
      assign loop_val[g] = loop_cnt[g*NW +: NW];
    end else begin : g_no
      assign loop_on[g]  = 1'b0;
      assign loop_val[g] = '0;
    end
  end

  dma_pending #(.NCH(NCH)) u_pend (
    .clk(clk), .rst_n(rst_sn), .req(chan_req), .clr(clr), .swap(swap),
    .pend(pend), .alt(alt)
  );

  dma_arb #(.NCH(NCH)) u_arb (.pend(pend), .any(any), .idx(widx));

  dma_addr #(.AW(AW), .NW(NW)) u_src (
    .end_ptr(src_end), .remain(ctl.remain), .step(ctl.src_step), .addr(saddr)
  );
  dma_addr #(.AW(AW), .NW(NW)) u_dst (
    .end_ptr(dst_end), .remain(ctl.remain), .step(ctl.dst_step), .addr(daddr)
  );

  assign dbase = (tbl_base & ~AW'(255)) + (alt[cur] ? AW'(256) : AW'(0)) + (AW'(cur) << 4);
  assign bc_p1 = bcnt + BW'(1);
  assign blen  = BW'(1) << ctl.batch_exp;

  // next state
  always_comb begin
    st_n   = st;
    cur_n  = cur;
    ctl_n  = ctl;
    bcnt_n = bcnt;
    fin_n  = fin;
    ld_src = 1'b0; ld_dst = 1'b0; ld_ctl = 1'b0; ld_dat = 1'b0;
    ld_cur = 1'b0; ld_bc  = 1'b0; ld_fin = 1'b0;
    clr = '0; swap = '0; done_n = '0; err_n = '0;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0; mem_size = 2'd2;
    case (st)
      S_IDLE: if (any) begin
        cur_n = widx; ld_cur = 1'b1; st_n = S_FSRC;
      end
      S_FSRC: begin
        mem_req = 1'b1; mem_addr = dbase;
        if (mem_gnt) begin ld_src = 1'b1; st_n = S_FDST; end
      end
      S_FDST: begin
        mem_req = 1'b1; mem_addr = dbase + AW'(4);
        if (mem_gnt) begin ld_dst = 1'b1; st_n = S_FCTL; end
      end
      S_FCTL: begin
        mem_req = 1'b1; mem_addr = dbase + AW'(8);
        if (mem_gnt) begin ctl_n = ctl_t'(mem_rdata); ld_ctl = 1'b1; st_n = S_CHK; end
      end
      S_CHK: begin
        if (ctl.mode == MODE_STOP) begin
          clr[cur] = 1'b1; st_n = S_IDLE;
        end else if (ctl_bad(ctl)) begin
          clr[cur] = 1'b1; err_n[cur] = 1'b1; st_n = S_IDLE;
        end else begin
          bcnt_n = '0; ld_bc = 1'b1; st_n = S_RD;
        end
      end
      S_RD: begin
        mem_req = 1'b1; mem_addr = saddr; mem_size = ctl.src_size;
        if (mem_gnt) begin ld_dat = 1'b1; st_n = S_WR; end
      end
      S_WR: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = daddr;
        mem_wdata = dat; mem_size = ctl.dst_size;
        if (mem_gnt) begin
          ld_ctl = 1'b1; ld_fin = 1'b1;
          if (ctl.remain == '0) begin
            st_n = S_WB;
            if (loop_on[cur]) begin
              ctl_n.remain = loop_val[cur]; fin_n = FIN_LOOP;
            end else begin
              ctl_n.mode = MODE_STOP;
              fin_n = (ctl.mode == MODE_PING) ? FIN_SWAP : FIN_STOP;
            end
          end else begin
            ctl_n.remain = ctl.remain - NW'(1);
            fin_n = FIN_NONE;
            if (bc_p1 == blen) begin
              st_n = S_WB;
            end else begin
              bcnt_n = bc_p1; ld_bc = 1'b1; st_n = S_RD;
            end
          end
        end
      end
      S_WB: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = dbase + AW'(8); mem_wdata = ctl;
        if (mem_gnt) begin
          st_n = S_IDLE;
          if (fin != FIN_NONE) done_n[cur] = 1'b1;
          if (fin == FIN_STOP) clr[cur]  = 1'b1;
          if (fin == FIN_SWAP) swap[cur] = 1'b1;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st        <= S_IDLE;
      cur       <= '0;
      src_end   <= '0;
      dst_end   <= '0;
      ctl       <= '0;
      dat       <= '0;
      bcnt      <= '0;
      fin       <= FIN_NONE;
      chan_done <= '0;
      chan_err  <= '0;
    end else begin
      st        <= st_n;
      chan_done <= done_n;
      chan_err  <= err_n;
      if (ld_cur) cur     <= cur_n;
      if (ld_src) src_end <= mem_rdata;
      if (ld_dst) dst_end <= mem_rdata;
      if (ld_ctl) ctl     <= ctl_n;
      if (ld_dat) dat     <= mem_rdata;
      if (ld_bc)  bcnt    <= bcnt_n;
      if (ld_fin) fin     <= fin_n;
    end
  end

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int NCH = 4,
  parameter int AW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req,
  input logic           mem_gnt,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [NCH-1:0] chan_done,
  input logic [NCH-1:0] chan_err
);

  a_r11_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r6_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_done));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_done != '0) |=> (chan_done == '0));

  a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_done != '0) |-> $past(mem_req && mem_gnt && mem_we));

  a_r9_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_err != '0) |-> !mem_we);

  a_r9_err_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_err != '0) |-> (chan_done == '0));

endmodule

bind dma_engine dma_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_sn), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
  .mem_addr(mem_addr), .chan_done(chan_done), .chan_err(chan_err)
);

// File: tb/sim_dma_engine.sv
module sim_dma_engine;

  localparam int NCH = 4;
  localparam int AW  = 32;
  localparam int BASE = 32'h400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] tbl_base = BASE;
  logic [1:0]  loop_en = 2'b00;
  logic [19:0] loop_cnt = '0;
  logic [NCH-1:0] chan_req = '0;
  logic [NCH-1:0] chan_done, chan_err;
  logic mem_req, mem_gnt, mem_we;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;
  logic [31:0] mem_wdata, mem_rdata;
  logic stall = 1'b0;

  logic [31:0] mem [0:511];
  logic [31:0] wl_a [0:255];
  logic [1:0]  wl_s [0:255];
  logic [31:0] cl_a [0:255];
  logic [31:0] cl_d [0:255];
  int wcnt = 0, ccnt = 0, ecnt = 0, cyc = 0;
  int dcnt [NCH] = '{0, 0, 0, 0};
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  dma_engine u0 (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .loop_en(loop_en), .loop_cnt(loop_cnt),
    .chan_req(chan_req), .chan_done(chan_done), .chan_err(chan_err),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_gnt   = !stall || cyc[0];
  assign mem_rdata = mem[mem_addr[10:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_gnt && mem_we) begin
      mem[mem_addr[10:2]] <= mem_wdata;
      if (mem_addr < BASE) begin
        wl_a[wcnt[7:0]] <= mem_addr; wl_s[wcnt[7:0]] <= mem_size; wcnt <= wcnt + 1;
      end else begin
        cl_a[ccnt[7:0]] <= mem_addr; cl_d[ccnt[7:0]] <= mem_wdata; ccnt <= ccnt + 1;
      end
    end
    for (int c = 0; c < NCH; c++) if (chan_done[c]) dcnt[c] <= dcnt[c] + 1;
    if (chan_err != '0) ecnt <= ecnt + 1;
  end

  function automatic logic [31:0] pat(input int i);
    return 32'hA500_0000 ^ i;
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] step, input logic [1:0] dsz,
      input logic [1:0] ssz, input logic [3:0] r, input logic [9:0] n, input logic [2:0] mode);
    return {step, dsz, step, ssz, 6'b0, r, n, 1'b1, mode};
  endfunction

  function automatic logic [31:0] stopped(input logic [31:0] c);
    return c & ~32'h0000_3FF7;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setdesc(input int ch, input int alt, input int se, input int de, input logic [31:0] c);
    int b;
    b = BASE + alt * 256 + ch * 16;
    mem[b >> 2] <= se; mem[(b >> 2) + 1] <= de; mem[(b >> 2) + 2] <= c;
    @(negedge clk);
  endtask

  task automatic fill_data();
    for (int i = 0; i < 128; i++) mem[i] <= pat(i);
    for (int i = 128; i < 256; i++) mem[i] <= '0;
    @(negedge clk);
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); chan_req[ch] = 1'b1;
    @(negedge clk); chan_req[ch] = 1'b0;
  endtask

  task automatic settle();
    int quiet = 0;
    for (int k = 0; k < 4000 && quiet < 8; k++) begin
      @(negedge clk);
      quiet = mem_req ? 0 : quiet + 1;
    end
  endtask

  // {13'd0, N[18:9], step[8:7], size[6:5], R[4:1], stall[0]}
  localparam logic [31:0] VEC [6] = '{
    {13'd0, 10'd0, 2'd2, 2'd2, 4'd0,  1'b0},
    {13'd0, 10'd3, 2'd2, 2'd2, 4'd2,  1'b1},
    {13'd0, 10'd5, 2'd3, 2'd2, 4'd1,  1'b0},
    {13'd0, 10'd4, 2'd1, 2'd1, 4'd3,  1'b1},
    {13'd0, 10'd2, 2'd0, 2'd0, 4'd0,  1'b0},
    {13'd0, 10'd9, 2'd2, 2'd2, 4'd15, 1'b1}
  };

  initial begin
    #1500000;
    nfail++; nchk++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int w0, c0, d0, d1, e0, bad, nb;
    logic [31:0] c, ea;
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!mem_req && chan_done == '0 && chan_err == '0, "R1 outputs quiet in reset",
        {mem_req, chan_done, chan_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_req && chan_done == '0 && chan_err == '0, "R1 outputs quiet after reset",
        {mem_req, chan_done, chan_err}, 0);

    // table walk: basic mode on channel 0
    for (int v = 0; v < 6; v++) begin
      int n, stp, sz, r, bl, nbatch;
      n = VEC[v][18:9]; stp = VEC[v][8:7]; sz = VEC[v][6:5]; r = VEC[v][4:1];
      fill_data();
      c = mk(2'(stp), 2'(sz), 2'(sz), 4'(r), 10'(n), 3'd1);
      setdesc(0, 0, 32'h1FC, 32'h3FC, c);
      stall = VEC[v][0];
      w0 = wcnt; c0 = ccnt; d0 = dcnt[0];
      pulse(0);
      settle();
      stall = 1'b0;
      chk(wcnt - w0 == n + 1, "R4 item count", wcnt - w0, n + 1);
      bad = 0;
      for (int k = 0; k <= n; k++) begin
        ea = (stp == 3) ? 32'h3FC : 32'h3FC - ((n - k) << stp);
        if (wl_a[(w0 + k) & 255] != ea || wl_s[(w0 + k) & 255] != 2'(sz)) bad++;
      end
      chk(bad == 0, "R4 write address and size sequence", bad, 0);
      if (stp == 2) begin
        bad = 0;
        for (int k = 0; k <= n; k++)
          if (mem[(32'h3FC - ((n - k) << 2)) >> 2] != pat((32'h1FC - ((n - k) << 2)) >> 2)) bad++;
        chk(bad == 0, "R11 R4 copied data under grant stalls", bad, 0);
      end
      chk(mem[(BASE + 8) >> 2] == stopped(c), "R3 R6 final control word",
          mem[(BASE + 8) >> 2], stopped(c));
      chk(dcnt[0] - d0 == 1, "R6 R12 one done pulse", dcnt[0] - d0, 1);
      bl = (r >= 11) ? 2048 : (1 << r);
      nbatch = (n + bl) / bl;
      chk(ccnt - c0 == nbatch, "R5 writeback count", ccnt - c0, nbatch);
      bad = 0;
      for (int k = 0; k < nbatch - 1; k++)
        if (cl_d[(c0 + k) & 255][13:4] != 10'(n - (k + 1) * bl) || cl_d[(c0 + k) & 255][2:0] != 3'd1) bad++;
      chk(bad == 0, "R5 intermediate remaining count", bad, 0);
    end

    // R9: size mismatch, then +4 step with halfword
    w0 = wcnt; c0 = ccnt; e0 = ecnt; d0 = dcnt[2];
    setdesc(2, 0, 32'h1FC, 32'h3FC, {2'd2, 2'd1, 2'd2, 2'd2, 6'b0, 4'd0, 10'd3, 1'b0, 3'd1});
    pulse(2); settle();
    setdesc(2, 0, 32'h1FC, 32'h3FC, mk(2'd2, 2'd1, 2'd1, 4'd0, 10'd3, 3'd1));
    pulse(2); settle();
    chk(ecnt - e0 == 2, "R9 error pulses", ecnt - e0, 2);
    chk(wcnt == w0 && ccnt == c0, "R9 no access after illegal descriptor", wcnt - w0 + ccnt - c0, 0);
    chk(dcnt[2] == d0, "R9 no done on error", dcnt[2] - d0, 0);

    // R10: stop mode
    w0 = wcnt; c0 = ccnt; e0 = ecnt; d0 = dcnt[3];
    setdesc(3, 0, 32'h1FC, 32'h3FC, mk(2'd2, 2'd2, 2'd2, 4'd0, 10'd3, 3'd0));
    pulse(3); settle();
    chk(wcnt == w0 && ccnt == c0 && ecnt == e0 && dcnt[3] == d0, "R10 stop mode inert",
        wcnt - w0 + ccnt - c0, 0);

    // R5 R12: re-arbitration at a batch boundary
    fill_data();
    setdesc(1, 0, 32'h1FC, 32'h3FC, mk(2'd2, 2'd2, 2'd2, 4'd1, 10'd7, 3'd1));
    setdesc(0, 0, 32'h0FC, 32'h2FC, mk(2'd2, 2'd2, 2'd2, 4'd0, 10'd0, 3'd1));
    w0 = wcnt; c0 = ccnt; d0 = dcnt[0]; d1 = dcnt[1];
    pulse(1);
    for (int k = 0; k < 200 && wcnt == w0; k++) @(negedge clk);
    pulse(0);
    settle();
    chk(wl_a[(w0 + 2) & 255] == 32'h2FC, "R5 R12 higher channel served at boundary",
        wl_a[(w0 + 2) & 255], 32'h2FC);
    chk(wcnt - w0 == 9, "R5 total writes after re-arbitration", wcnt - w0, 9);
    chk(cl_d[c0 & 255][13:4] == 10'd5, "R5 first writeback count", cl_d[c0 & 255][13:4], 5);
    chk(dcnt[0] - d0 == 1 && dcnt[1] - d1 == 1, "R12 both channels done",
        dcnt[0] - d0 + dcnt[1] - d1, 2);

    // R7 R2: ping-pong on channel 2
    fill_data();
    setdesc(2, 0, 32'h0FC, 32'h2FC, mk(2'd2, 2'd2, 2'd2, 4'd4, 10'd1, 3'd3));
    setdesc(2, 1, 32'h1FC, 32'h3FC, mk(2'd2, 2'd2, 2'd2, 4'd4, 10'd2, 3'd3));
    w0 = wcnt; d0 = dcnt[2];
    pulse(2); settle();
    chk(wcnt - w0 == 5, "R7 writes across both descriptors", wcnt - w0, 5);
    chk(dcnt[2] - d0 == 2, "R7 done per descriptor", dcnt[2] - d0, 2);
    chk(mem[32'h2FC >> 2] == pat(32'h0FC >> 2) && mem[32'h3F4 >> 2] == pat(32'h1F4 >> 2),
        "R2 R7 data of primary and alternate", mem[32'h3F4 >> 2], pat(32'h1F4 >> 2));
    chk(mem[(BASE + 32'h28) >> 2][2:0] == 3'd0 && mem[(BASE + 32'h128) >> 2][2:0] == 3'd0,
        "R2 R7 both descriptors marked stop", mem[(BASE + 32'h128) >> 2], 0);
    fill_data();
    setdesc(2, 0, 32'h0FC, 32'h2FC, mk(2'd2, 2'd2, 2'd2, 4'd0, 10'd0, 3'd1));
    w0 = wcnt;
    pulse(2); settle();
    chk(wl_a[w0 & 255] == 32'h2FC, "R7 selector back on primary", wl_a[w0 & 255], 32'h2FC);

    // R8: loop on channel 1
    fill_data();
    loop_en = 2'b10; loop_cnt = {10'd1, 10'd0};
    setdesc(1, 0, 32'h1FC, 32'h3FC, mk(2'd2, 2'd2, 2'd2, 4'd4, 10'd2, 3'd1));
    w0 = wcnt; c0 = ccnt; d1 = dcnt[1];
    pulse(1);
    for (int k = 0; k < 400 && dcnt[1] == d1; k++) @(negedge clk);
    loop_en = 2'b00;
    settle();
    chk(cl_d[c0 & 255][13:4] == 10'd1 && cl_d[c0 & 255][2:0] == 3'd1, "R8 reload keeps mode",
        cl_d[c0 & 255], 32'h11);
    chk(wcnt - w0 == 5, "R8 transfers continue after reload", wcnt - w0, 5);
    chk(wl_a[(w0 + 3) & 255] == 32'h3F8, "R8 reloaded address", wl_a[(w0 + 3) & 255], 32'h3F8);
    chk(dcnt[1] - d1 == 2, "R8 done on reload and final", dcnt[1] - d1, 2);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule